// File: doc/BRIEF.md
# Single-Wire Slave ROM Command Unit

This unit is the network layer of a single-wire slave device. It sits above a bit-slot layer that reports one strobe for each time slot on the wire, with the bit the master left on the line in that slot. After every bus reset and presence sequence, the unit collects one ROM command byte, least significant bit first. It then applies that command to a 64-bit device identity. The identity is an 8-bit family code in the low bits, a 48-bit serial number above it, and an 8-bit CRC in the top bits. The identity is always handled bit 0 first.

Six commands are recognised:
- 33h reads the identity out.
- 55h matches a received identity.
- F0h runs one pass of the bitwise search.
- CCh selects the device with no identity transfer.
- 3Ch selects the device like CCh and also switches to overdrive speed.
- 69h switches to overdrive speed and then matches an identity sent at that speed.

A device that loses a match or a search, or that receives an unknown command, stays quiet until the next bus reset. The overdrive flag survives short bus resets. Only a reset of regular-speed length clears it. The unit reports which bit it wants on the wire in each read slot, whether it has been selected, and the speed flag.

Top module: `rom_cmd_unit`

## Requirements
- R1: After `rst_n` is released, `selected`, `overdrive` and `tx_en` are 0, and slot strobes have no effect until the first `line_reset` pulse.
- R2: After a `line_reset` pulse, the next 8 slots form the command byte, with the first slot as bit 0. A `line_reset` part way through a byte discards the partial byte and starts a new one.
- R3: Command 33h: in each of the next 64 slots `tx_en` is 1 and `tx_bit` equals identity bit k for slot k (k = 0..63). `selected` is 1 after the 64th slot.
- R4: Command 55h: the next 64 received slot bits are compared with identity bits 0..63. `selected` becomes 1 after the 64th slot only if every bit matched.
- R5: Command F0h: each identity bit k uses three slots. The first slot drives identity bit k, the second drives its complement (both with `tx_en` = 1), and the third receives the master's bit with `tx_en` = 0. The search continues only if the received bit equals identity bit k. `selected` is 1 after bit 63.
- R6: Command CCh sets `selected` in the cycle after the eighth command slot.
- R7: Command 3Ch sets both `selected` and `overdrive`. `overdrive` rises only as the result of a decoded 3Ch or 69h command.
- R8: Command 69h sets `overdrive` right after the command byte, then behaves as 55h.
- R9: A mismatch in a match or a search clears `selected` and `tx_en`. Both stay 0 for all further slots until the next `line_reset`.
- R10: Any other command value leaves `selected` and `tx_en` at 0 until the next `line_reset`.
- R11: `line_reset` clears `selected`. `overdrive` is cleared only when `reset_regular` is 1 during `line_reset`; otherwise it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_code | input | 64 | Device identity: family code [7:0], serial [55:8], CRC [63:56] |
| line_reset | input | 1 | One-cycle pulse: bus reset and presence finished |
| reset_regular | input | 1 | Qualifies `line_reset` as regular-speed length |
| slot_stb | input | 1 | One-cycle pulse at the end of each time slot |
| slot_rx | input | 1 | Bit seen on the line in that slot |
| tx_en | output | 1 | The device drives the current slot (read slot) |
| tx_bit | output | 1 | Bit the device drives in the current slot (1 = release) |
| selected | output | 1 | Device is selected for function commands |
| overdrive | output | 1 | Overdrive speed flag |

## Verification
A state machine that follows the wrong path shows up first on `tx_en` and `tx_bit`. A wrong identity index or search phase changes the driven bit in the very next read slot. A missed mismatch shows as `selected` being set one cycle after the final slot of the sequence. A speed flag that is set or cleared wrongly is visible at `overdrive` one cycle after the command byte or the reset pulse. Each of these shows within one cycle of the slot that caused it, so the bench compares every driven slot against the identity and checks the flags at each sequence end.

// File: rtl/rom_cmd_pkg.sv
package rom_cmd_pkg;

  typedef enum logic [2:0] {
    ST_QUIET,
    ST_CMD,
    ST_READ,
    ST_MATCH,
    ST_SEARCH,
    ST_DONE
  } rom_state_t;

  localparam logic [7:0] OP_READ     = 8'h33;
  localparam logic [7:0] OP_MATCH    = 8'h55;
  localparam logic [7:0] OP_SEARCH   = 8'hF0;
  localparam logic [7:0] OP_SKIP     = 8'hCC;
  localparam logic [7:0] OP_OD_SKIP  = 8'h3C;
  localparam logic [7:0] OP_OD_MATCH = 8'h69;

  // search slot phases: 0 = true bit, 1 = complement, 2 = master direction
  localparam logic [1:0] PH_TRUE = 2'd0;
  localparam logic [1:0] PH_COMP = 2'd1;
  localparam logic [1:0] PH_DIR  = 2'd2;

  function automatic logic search_tx(input logic idbit, input logic [1:0] ph);
    return (ph == PH_TRUE) ? idbit : ~idbit;
  endfunction

  function automatic rom_state_t next_after_cmd(input logic [7:0] op);
    case (op)
      OP_READ:                 return ST_READ;
      OP_MATCH, OP_OD_MATCH:   return ST_MATCH;
      OP_SEARCH:               return ST_SEARCH;
      OP_SKIP, OP_OD_SKIP:     return ST_DONE;
      default:                 return ST_QUIET;
    endcase
  endfunction

  function automatic logic op_selects_now(input logic [7:0] op);
    return (op == OP_SKIP) || (op == OP_OD_SKIP);
  endfunction

  function automatic logic op_sets_od(input logic [7:0] op);
    return (op == OP_OD_SKIP) || (op == OP_OD_MATCH);
  endfunction

endpackage

// File: rtl/rom_cmd_shift.sv
module rom_cmd_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] byte_next,
  output logic         byte_ready
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  sreg;
  logic [CW-1:0] cnt;

  assign byte_next  = {din, sreg[W-1:1]};
  assign byte_ready = shift && (cnt == CW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '0;
      cnt  <= '0;
    end else if (clear) begin
      cnt  <= '0;
    end else if (shift) begin
      sreg <= byte_next;
      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rom_bit_index.sv
module rom_bit_index #(
  parameter int N = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 adv,
  output logic [$clog2(N)-1:0] idx,
  output logic                 last
);
  localparam int IW = $clog2(N);

  assign last = (idx == IW'(N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx <= '0;
    else if (clear) idx <= '0;
    else if (adv)   idx <= idx + 1'b1;
  end
endmodule

// File: rtl/rom_cmd_unit.sv
module rom_cmd_unit
  import rom_cmd_pkg::*;
#(
  parameter int ID_W = 64,
  parameter int OP_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] id_code,
  input  logic            line_reset,
  input  logic            reset_regular,
  input  logic            slot_stb,
  input  logic            slot_rx,
  output logic            tx_en,
  output logic            tx_bit,
  output logic            selected,
  output logic            overdrive
);
  localparam int IW = $clog2(ID_W);

  rom_state_t      state;
  logic [1:0]      phase;
  logic [IW-1:0]   idx;
  logic            idx_last;
  logic            id_bit;
  logic [OP_W-1:0] op_next;

  // named internal events
  logic            live_slot;
  logic            cmd_ready;
  logic            cmp_slot;
  logic            mismatch_evt;
  logic            seq_end;
  logic            idx_adv;

  assign live_slot = slot_stb && !line_reset;
  assign id_bit    = id_code[idx];

  rom_cmd_shift #(.W(OP_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (line_reset),
    .shift      (live_slot && (state == ST_CMD)),
    .din        (slot_rx),
    .byte_next  (op_next),
    .byte_ready (cmd_ready)
  );

  assign cmp_slot = live_slot &&
                    ((state == ST_MATCH) || ((state == ST_SEARCH) && (phase == PH_DIR)));
  assign mismatch_evt = cmp_slot && (slot_rx != id_bit);
  assign idx_adv = (live_slot && (state == ST_READ)) || (cmp_slot && !mismatch_evt);
  assign seq_end = idx_adv && idx_last;

  rom_bit_index #(.N(ID_W)) u_idx (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (line_reset || cmd_ready),
    .adv   (idx_adv),
    .idx   (idx),
    .last  (idx_last)
  );

  assign tx_en  = (state == ST_READ) || ((state == ST_SEARCH) && (phase != PH_DIR));
  assign tx_bit = !tx_en ? 1'b1 :
                  (state == ST_READ) ? id_bit : search_tx(id_bit, phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_QUIET;
      phase     <= PH_TRUE;
      selected  <= 1'b0;
      overdrive <= 1'b0;
    end else if (line_reset) begin
      state    <= ST_CMD;
      phase    <= PH_TRUE;
      selected <= 1'b0;
      if (reset_regular) overdrive <= 1'b0;
    end else if (cmd_ready) begin
      state    <= next_after_cmd(op_next);
      phase    <= PH_TRUE;
      selected <= op_selects_now(op_next);
      if (op_sets_od(op_next)) overdrive <= 1'b1;
    end else if (mismatch_evt) begin
      state    <= ST_QUIET;
      selected <= 1'b0;
    end else if (seq_end) begin
      state    <= ST_DONE;
      selected <= 1'b1;
    end else if (live_slot && (state == ST_SEARCH)) begin
      phase <= (phase == PH_DIR) ? PH_TRUE : phase + 1'b1;
    end
  end
endmodule

// File: rtl/rom_cmd_checker.sv
module rom_cmd_checker (
  input logic clk,
  input logic rst_n,
  input logic line_reset,
  input logic reset_regular,
  input logic cmd_ready,
  input logic mismatch_evt,
  input logic seq_end,
  input logic tx_en,
  input logic selected,
  input logic overdrive
);
  assert_reset_clears_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    line_reset |=> !selected);

  assert_regular_clears_od_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (line_reset && reset_regular) |=> !overdrive);

  assert_od_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_reset && !cmd_ready) |=> (overdrive == $past(overdrive)));

  assert_od_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overdrive) |-> $past(cmd_ready));

  assert_quiet_after_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_evt |=> (!selected && !tx_en));

  assert_sel_after_seq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_end && !line_reset) |=> selected);

  assert_tx_unselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> !selected);
endmodule

bind rom_cmd_unit rom_cmd_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .line_reset    (line_reset),
  .reset_regular (reset_regular),
  .cmd_ready     (cmd_ready),
  .mismatch_evt  (mismatch_evt),
  .seq_end       (seq_end),
  .tx_en         (tx_en),
  .selected      (selected),
  .overdrive     (overdrive)
);

// File: tb/sim_rom_cmd_unit.sv
module sim_rom_cmd_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] id_code = 64'h9E_0123456789AB_2D;
  logic        line_reset = 1'b0;
  logic        reset_regular = 1'b0;
  logic        slot_stb = 1'b0;
  logic        slot_rx = 1'b1;
  logic        tx_en, tx_bit, selected, overdrive;

  int checks = 0;
  int errors = 0;
  logic od_m = 1'b0;

  always #2.5 clk = ~clk;

  rom_cmd_unit u0 (
    .clk(clk), .rst_n(rst_n), .id_code(id_code), .line_reset(line_reset),
    .reset_regular(reset_regular), .slot_stb(slot_stb), .slot_rx(slot_rx),
    .tx_en(tx_en), .tx_bit(tx_bit), .selected(selected), .overdrive(overdrive)
  );

  // {opcode[7:0], flip, flip_index[5:0], regular_reset}
  localparam int NV = 12;
  localparam logic [15:0] VEC [NV] = '{
    {8'h33, 1'b0, 6'd0,  1'b1},
    {8'h55, 1'b0, 6'd0,  1'b1},
    {8'h55, 1'b1, 6'd37, 1'b1},
    {8'hF0, 1'b0, 6'd0,  1'b1},
    {8'hF0, 1'b1, 6'd5,  1'b1},
    {8'hCC, 1'b0, 6'd0,  1'b1},
    {8'h3C, 1'b0, 6'd0,  1'b1},
    {8'h55, 1'b0, 6'd0,  1'b0},
    {8'h69, 1'b1, 6'd63, 1'b0},
    {8'hA5, 1'b0, 6'd0,  1'b1},
    {8'h69, 1'b0, 6'd0,  1'b1},
    {8'hF0, 1'b1, 6'd63, 1'b1}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic slot(input logic b);
    @(negedge clk);
    slot_stb = 1'b1;
    slot_rx  = b;
    @(negedge clk);
    slot_stb = 1'b0;
    slot_rx  = 1'b1;
  endtask

  task automatic bus_reset(input logic regular);
    @(negedge clk);
    line_reset    = 1'b1;
    reset_regular = regular;
    @(negedge clk);
    line_reset    = 1'b0;
    reset_regular = 1'b0;
    if (regular) od_m = 1'b0;
  endtask

  task automatic send_op(input logic [7:0] op);
    for (int i = 0; i < 8; i++) slot(op[i]);
  endtask

  task automatic run_vec(input logic [15:0] v);
    logic [7:0] op;
    logic       flip, known, ok, alive;
    int         fi;
    op = v[15:8]; flip = v[7]; fi = int'(v[6:1]);
    bus_reset(v[0]);
    send_op(op);
    if (op == 8'h3C || op == 8'h69) od_m = 1'b1;
    known = (op == 8'h33 || op == 8'h55 || op == 8'hF0 || op == 8'hCC ||
             op == 8'h3C || op == 8'h69);
    ok = 1'b1;
    if (op == 8'h33) begin
      for (int k = 0; k < 64; k++) begin
        if (!(tx_en === 1'b1 && tx_bit === id_code[k])) ok = 1'b0;
        slot(1'b1);
      end
      check("R3 read bits", {63'd0, ok}, 64'd1);
    end else if (op == 8'h55 || op == 8'h69) begin
      check("R8 od after 69h / R4 match start", {63'd0, overdrive}, {63'd0, od_m});
      for (int k = 0; k < 64; k++) begin
        if (tx_en !== 1'b0) ok = 1'b0;
        slot(id_code[k] ^ (flip && k == fi));
      end
      check("R4 R9 match quiet line", {63'd0, ok}, 64'd1);
    end else if (op == 8'hF0) begin
      alive = 1'b1;
      for (int k = 0; k < 64; k++) begin
        if (alive) begin
          if (!(tx_en === 1'b1 && tx_bit === id_code[k])) ok = 1'b0;
          slot(1'b1);
          if (!(tx_en === 1'b1 && tx_bit === ~id_code[k])) ok = 1'b0;
          slot(1'b1);
          if (tx_en !== 1'b0) ok = 1'b0;
          slot(id_code[k] ^ (flip && k == fi));
          if (flip && k == fi) alive = 1'b0;
        end else begin
          if (tx_en !== 1'b0) ok = 1'b0;
          slot(1'b0);
        end
      end
      check("R5 R9 search slots", {63'd0, ok}, 64'd1);
    end else if (!known) begin
      for (int k = 0; k < 4; k++) begin
        if (tx_en !== 1'b0) ok = 1'b0;
        slot(1'b0);
      end
      check("R10 unknown op quiet", {63'd0, ok}, 64'd1);
    end
    check($sformatf("R6 R7 selected op %02h", op), {63'd0, selected},
          {63'd0, known && !flip});
    check($sformatf("R11 overdrive op %02h", op), {63'd0, overdrive}, {63'd0, od_m});
    check("R9 idle after sequence", {63'd0, tx_en}, 64'd0);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset selected", {63'd0, selected}, 64'd0);
    check("R1 reset overdrive", {63'd0, overdrive}, 64'd0);
    check("R1 reset tx_en", {63'd0, tx_en}, 64'd0);
    // slots before any bus reset do nothing
    send_op(8'hCC);
    check("R1 slots ignored before line_reset", {63'd0, selected}, 64'd0);

    for (int n = 0; n < NV; n++) run_vec(VEC[n]);

    // partial byte discarded by a new bus reset
    bus_reset(1'b1);
    for (int i = 0; i < 4; i++) slot(1'b1);
    bus_reset(1'b1);
    send_op(8'hCC);
    check("R2 restart after partial byte", {63'd0, selected}, 64'd1);

    // short reset keeps overdrive, regular reset clears it
    bus_reset(1'b1);
    send_op(8'h3C);
    check("R7 overdrive skip", {63'd0, overdrive}, 64'd1);
    bus_reset(1'b0);
    check("R11 short reset keeps od", {63'd0, overdrive}, 64'd1);
    check("R11 short reset clears selected", {63'd0, selected}, 64'd0);
    bus_reset(1'b1);
    check("R11 regular reset clears od", {63'd0, overdrive}, 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule